// File: doc/BRIEF.md
# Flash command cycle sequencer

This block is the command front end of a sector-organised flash device model. An external controller writes bytes over an 8-bit bus. A command/address select input marks each byte as a command or an address. A write strobe captures the byte on its rising edge. A separate serial data strobe, also captured on its rising edge, stands for program data bytes. The sequencer decodes the multi-cycle command sequences: read, program, single-sector erase, identifier read, abort and status clear. It assembles a 14-bit sector number from two address cycles. It also assembles 12-bit column numbers from two address cycles each, and a column pair may be repeated any number of times within one read or program. It counts the bus cycles of the current operation.

When a sequence completes, the block emits a one-cycle operation pulse. The pulse carries the opening opcode, the latched sector, the column and a column-range flag. Erase and program start a busy window of fixed length. During that window every strobe is ignored. A read-back byte shows one of three things: the status register, the identifier code or the (absent) array data. Status mode is the one selected after reset.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, data_o is the status byte 0x80 (bit 7 = ready, bit 5 = command error, bit 4 = column error, other bits 0). busy_o, op_valid_o and cycle_o are 0.
- R2: A command byte 0x00 followed by two address bytes (sector bits 7:0, then sector bits 13:8 in byte bits 5:0) produces a pulse with opcode 0x00, that sector, column 0 and cycle_o = 3. data_o then reads 0x00 (array mode).
- R3: In a read, each following pair of address bytes (column bits 7:0, then column bits 11:8 in byte bits 3:0) produces a pulse with that column, and cycle_o = 3 + 2h after h pairs.
- R4: A column above 0x83F raises op_col_err_o with its pulse and sets status bit 4, which stays set until cleared. Columns up to 0x83F leave op_col_err_o low.
- R5: Command 0x60, two sector bytes and command 0xD0 produce a pulse with opcode 0x60, that sector and cycle_o = 4, and start the busy window.
- R6: Command 0x80, two sector bytes, h column pairs, at least one serial data strobe and command 0x40 produce a pulse with opcode 0x80, the last column and cycle_o = 4 + 2h, and start the busy window. A 0x40 with no data strobe gives no pulse and sets status bit 5.
- R7: busy_o is high for exactly BUSY_CYC clock cycles, starting the cycle after the confirm byte is captured. In status mode, bit 7 of data_o is the inverse of busy_o.
- R8: A write strobe rising while busy_o is high is ignored, including one in the last busy cycle. A strobe that rises after busy_o falls is accepted.
- R9: Command 0x90 produces a pulse with opcode 0x90 and selects identifier mode, where data_o is 0x07 while code_sel_i is low and 0x99 while it is high.
- R10: A command byte that opens no sequence, and an address byte when no address is expected, give no pulse, return to idle with cycle_o = 0 and set status bit 5.
- R11: Command 0xFF aborts any partly entered sequence, clears cycle_o to 0, selects status mode and produces a pulse with opcode 0xFF.
- R12: Command 0x50 clears status bits 5 and 4 and produces a pulse with opcode 0x50.
- R13: op_valid_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe; byte captured on its rising edge |
| cmd_sel_i | input | 1 | High: byte is a command; low: byte is an address |
| bus_i | input | 8 | Command or address byte |
| ser_clk_i | input | 1 | Serial data strobe; each rising edge is one program data byte |
| code_sel_i | input | 1 | Selects manufacturer (low) or device (high) identifier |
| data_o | output | 8 | Status, identifier or array read-back byte |
| busy_o | output | 1 | High during the erase/program busy window |
| op_valid_o | output | 1 | One-cycle pulse for a completed sequence |
| op_code_o | output | 8 | Opening opcode of the completed sequence |
| op_sector_o | output | 14 | Latched sector number |
| op_col_o | output | 12 | Column of the completed operation |
| op_col_err_o | output | 1 | Column above 0x83F |
| cycle_o | output | 13 | Bus cycles counted in the current operation |

## Verification
The collision that matters is the end of the busy window meeting a new command write. The bench raises the write strobe so that it is captured on the edge where busy_o is still high for its final cycle. That write must leave both the pulse output and the read-back mode unchanged. It then writes the same identifier command one strobe later and expects it to be accepted. The busy window is measured cycle by cycle against BUSY_CYC, so an off-by-one in either the counter or the gating shows up as a wrong width or a wrongly accepted write.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [7:0] OPC_READ   = 8'h00;
    localparam logic [7:0] OPC_PROG   = 8'h80;
    localparam logic [7:0] OPC_ERASE  = 8'h60;
    localparam logic [7:0] OPC_IDENT  = 8'h90;
    localparam logic [7:0] OPC_CLEAR  = 8'h50;
    localparam logic [7:0] OPC_ABORT  = 8'hFF;
    localparam logic [7:0] CONF_PROG  = 8'h40;
    localparam logic [7:0] CONF_ERASE = 8'hD0;

    localparam logic [7:0] ID_MAKER   = 8'h07;
    localparam logic [7:0] ID_PART    = 8'h99;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SEC_LO, PH_SEC_HI, PH_COL_LO, PH_COL_HI, PH_CONFIRM
    } phase_t;

    typedef enum logic [1:0] {SEQ_NONE, SEQ_READ, SEQ_PROG, SEQ_ERASE} seq_t;

    typedef enum logic [1:0] {OUT_STATUS, OUT_IDENT, OUT_ARRAY} out_t;

    typedef struct packed {
        logic ready;
        logic cmd_err;
        logic col_err;
    } status_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {s.ready, 1'b0, s.cmd_err, s.col_err, 4'b0000};
    endfunction

endpackage

// File: rtl/fcs_strobe_rise.sv
module fcs_strobe_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
    parameter int BUSY_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int BUSY_W = $clog2(BUSY_CYC + 1);

    logic [BUSY_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)             remain <= '0;
        else if (start_i)    remain <= BUSY_W'(BUSY_CYC);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy_o = (remain != '0);

    // R8: the sequencer must never try to start a window while one runs
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !start_i);
endmodule

// File: rtl/fcs_out_mux.sv
module fcs_out_mux
    import fcs_pkg::*;
(
    input  out_t       mode_i,
    input  status_t    status_i,
    input  logic       code_sel_i,
    output logic [7:0] data_o
);
    always_comb begin
        unique case (mode_i)
            OUT_IDENT: data_o = code_sel_i ? ID_PART : ID_MAKER;
            OUT_ARRAY: data_o = 8'h00;
            default:   data_o = pack_status(status_i);
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int SEC_W    = 14,
    parameter int COL_W    = 12,
    parameter int COL_MAX  = 'h83F,
    parameter int CYC_W    = 13,
    parameter int BUSY_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic             cmd_sel_i,
    input  logic [7:0]       bus_i,
    input  logic             ser_clk_i,
    input  logic             code_sel_i,
    output logic [7:0]       data_o,
    output logic             busy_o,
    output logic             op_valid_o,
    output logic [7:0]       op_code_o,
    output logic [SEC_W-1:0] op_sector_o,
    output logic [COL_W-1:0] op_col_o,
    output logic             op_col_err_o,
    output logic [CYC_W-1:0] cycle_o
);
    localparam logic [COL_W-1:0] COL_LIMIT = COL_W'(COL_MAX);
    localparam logic [CYC_W-1:0] CYC_TOP   = {CYC_W{1'b1}};

    // strobe edge detection: index 0 = write strobe, 1 = serial data strobe
    logic [1:0] lvl, rise;
    assign lvl = {ser_clk_i, wr_en_i};

    for (genvar g = 0; g < 2; g++) begin : g_edge
        fcs_strobe_rise u_rise (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (lvl[g]),
            .rise_o (rise[g])
        );
    end

    logic wr_ok, ser_ok;
    assign wr_ok  = rise[0] & ~busy_o;
    assign ser_ok = rise[1] & ~busy_o;

    // sequencer state
    phase_t           phase, ph_n;
    seq_t             seq, seq_n;
    out_t             mode, mode_n;
    logic [SEC_W-1:0] sector, sec_n;
    logic [COL_W-1:0] col, col_n;
    logic [7:0]       col_lo, lo_n;
    logic [7:0]       opcode, opc_n;
    logic             data_seen, seen_n;
    logic [CYC_W-1:0] cyc, cyc_n, cyc_inc;
    status_t          stat, stat_n;

    logic             fire, start_busy;
    logic [7:0]       fire_code;
    logic [COL_W-1:0] fire_col;

    always_comb begin
        ph_n = phase;  seq_n = seq;   mode_n = mode;  sec_n = sector;
        col_n = col;   lo_n = col_lo; opc_n = opcode; seen_n = data_seen;
        cyc_n = cyc;   stat_n = stat;
        fire = 1'b0;   start_busy = 1'b0;
        fire_code = opcode;
        fire_col  = col;
        cyc_inc = (cyc == CYC_TOP) ? cyc : cyc + 1'b1;

        if (ser_ok && seq == SEQ_PROG && phase == PH_COL_LO) seen_n = 1'b1;

        if (wr_ok) begin
            if (!cmd_sel_i) begin
                unique case (phase)
                    PH_SEC_LO: begin
                        sec_n[7:0] = bus_i;
                        ph_n = PH_SEC_HI;
                        cyc_n = cyc_inc;
                    end
                    PH_SEC_HI: begin
                        sec_n[SEC_W-1:8] = bus_i[SEC_W-9:0];
                        col_n = '0;
                        cyc_n = cyc_inc;
                        ph_n = (seq == SEQ_ERASE) ? PH_CONFIRM : PH_COL_LO;
                        if (seq == SEQ_READ) begin
                            fire = 1'b1;
                            fire_col = '0;
                        end
                    end
                    PH_COL_LO: begin
                        lo_n = bus_i;
                        ph_n = PH_COL_HI;
                        cyc_n = cyc_inc;
                    end
                    PH_COL_HI: begin
                        col_n = {bus_i[COL_W-9:0], col_lo};
                        ph_n = PH_COL_LO;
                        cyc_n = cyc_inc;
                        if (col_n > COL_LIMIT) stat_n.col_err = 1'b1;
                        if (seq == SEQ_READ) begin
                            fire = 1'b1;
                            fire_col = col_n;
                        end
                    end
                    default: begin
                        stat_n.cmd_err = 1'b1;
                        ph_n = PH_IDLE;
                        seq_n = SEQ_NONE;
                        cyc_n = '0;
                    end
                endcase
            end else if (seq == SEQ_ERASE && phase == PH_CONFIRM && bus_i == CONF_ERASE) begin
                fire = 1'b1;
                start_busy = 1'b1;
                cyc_n = cyc_inc;
                ph_n = PH_IDLE;
                seq_n = SEQ_NONE;
                mode_n = OUT_STATUS;
            end else if (seq == SEQ_PROG && phase == PH_COL_LO && bus_i == CONF_PROG) begin
                ph_n = PH_IDLE;
                seq_n = SEQ_NONE;
                if (data_seen) begin
                    fire = 1'b1;
                    start_busy = 1'b1;
                    cyc_n = cyc_inc;
                    mode_n = OUT_STATUS;
                end else begin
                    stat_n.cmd_err = 1'b1;
                    cyc_n = '0;
                end
            end else begin
                fire_code = bus_i;
                fire_col = '0;
                ph_n = PH_IDLE;
                seq_n = SEQ_NONE;
                cyc_n = CYC_W'(1);
                unique case (bus_i)
                    OPC_READ: begin
                        seq_n = SEQ_READ;  ph_n = PH_SEC_LO;
                        opc_n = bus_i;     mode_n = OUT_ARRAY;
                    end
                    OPC_PROG: begin
                        seq_n = SEQ_PROG;  ph_n = PH_SEC_LO;
                        opc_n = bus_i;     seen_n = 1'b0;
                    end
                    OPC_ERASE: begin
                        seq_n = SEQ_ERASE; ph_n = PH_SEC_LO;
                        opc_n = bus_i;
                    end
                    OPC_IDENT: begin
                        fire = 1'b1;
                        mode_n = OUT_IDENT;
                    end
                    OPC_CLEAR: begin
                        fire = 1'b1;
                        stat_n.cmd_err = 1'b0;
                        stat_n.col_err = 1'b0;
                    end
                    OPC_ABORT: begin
                        fire = 1'b1;
                        cyc_n = '0;
                        mode_n = OUT_STATUS;
                    end
                    default: begin
                        stat_n.cmd_err = 1'b1;
                        cyc_n = '0;
                    end
                endcase
            end
        end
        stat_n.ready = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;   seq <= SEQ_NONE;  mode <= OUT_STATUS;
            sector <= '0;       col <= '0;        col_lo <= '0;
            opcode <= '0;       data_seen <= 1'b0; cyc <= '0;
            stat <= '{ready: 1'b1, cmd_err: 1'b0, col_err: 1'b0};
            op_valid_o <= 1'b0; op_code_o <= '0;  op_sector_o <= '0;
            op_col_o <= '0;     op_col_err_o <= 1'b0;
        end else begin
            phase <= ph_n;      seq <= seq_n;     mode <= mode_n;
            sector <= sec_n;    col <= col_n;     col_lo <= lo_n;
            opcode <= opc_n;    data_seen <= seen_n; cyc <= cyc_n;
            stat <= stat_n;
            op_valid_o <= fire;
            if (fire) begin
                op_code_o    <= fire_code;
                op_sector_o  <= sec_n;
                op_col_o     <= fire_col;
                op_col_err_o <= (fire_col > COL_LIMIT);
            end
        end
    end

    fcs_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_busy),
        .busy_o  (busy_o)
    );

    status_t stat_view;
    always_comb begin
        stat_view = stat;
        stat_view.ready = ~busy_o;
    end

    fcs_out_mux u_mux (
        .mode_i     (mode),
        .status_i   (stat_view),
        .code_sel_i (code_sel_i),
        .data_o     (data_o)
    );

    assign cycle_o = cyc;

    assert_one_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |=> !op_valid_o);

    assert_busy_blocks_ops_R8: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !op_valid_o);

    assert_ready_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == OUT_STATUS) |-> (data_o[7] == !busy_o));

    assert_abort_clears_cycles_R11: assert property (@(posedge clk) disable iff (rst)
        (op_valid_o && op_code_o == OPC_ABORT) |-> (cycle_o == '0));
endmodule

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
    localparam int B = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en_i = 1'b0, cmd_sel_i = 1'b0, ser_clk_i = 1'b0, code_sel_i = 1'b0;
    logic [7:0]  bus_i = 8'h00;
    logic [7:0]  data_o, op_code_o;
    logic        busy_o, op_valid_o, op_col_err_o;
    logic [13:0] op_sector_o;
    logic [11:0] op_col_o;
    logic [12:0] cycle_o;

    int checks = 0, fails = 0;
    logic        v_s, ce_s;
    logic [7:0]  code_s;
    logic [13:0] sec_s;
    logic [11:0] col_s;
    logic [12:0] cyc_s;

    always #10 clk = ~clk;

    flash_cmd_seq dut (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .cmd_sel_i(cmd_sel_i),
        .bus_i(bus_i), .ser_clk_i(ser_clk_i), .code_sel_i(code_sel_i),
        .data_o(data_o), .busy_o(busy_o), .op_valid_o(op_valid_o),
        .op_code_o(op_code_o), .op_sector_o(op_sector_o), .op_col_o(op_col_o),
        .op_col_err_o(op_col_err_o), .cycle_o(cycle_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic c, input logic [7:0] b);
        @(negedge clk);
        cmd_sel_i = c; bus_i = b; wr_en_i = 1'b1;
        @(posedge clk); #2;
        v_s = op_valid_o; code_s = op_code_o; sec_s = op_sector_o;
        col_s = op_col_o; ce_s = op_col_err_o; cyc_s = cycle_o;
        @(negedge clk);
        wr_en_i = 1'b0;
        @(posedge clk); #2;
        if (v_s) chk("R13 pulse width", op_valid_o, 0);
    endtask

    task automatic ser_strobe();
        @(negedge clk); ser_clk_i = 1'b1;
        @(negedge clk); ser_clk_i = 1'b0;
    endtask

    task automatic wait_ready();
        while (busy_o) @(posedge clk);
        #2;
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #2;
        chk("R1 data", data_o, 8'h80);
        chk("R1 busy", busy_o, 0);
        chk("R1 valid", op_valid_o, 0);
        chk("R1 cycle", cycle_o, 0);

        // R2: read start over a sweep of sectors
        for (int k = 0; k <= 14; k++) begin
            int s;
            s = (k == 14) ? 16383 : k * 1171;
            bus_write(1, 8'h00);
            chk("R2 no early pulse", v_s, 0);
            bus_write(0, s[7:0]);
            bus_write(0, {2'b00, s[13:8]});
            chk("R2 valid", v_s, 1);
            chk("R2 code", code_s, 8'h00);
            chk("R2 sector", sec_s, s);
            chk("R2 col", col_s, 0);
            chk("R2 cycle", cyc_s, 3);
            chk("R2 array data", data_o, 8'h00);
        end

        // R3/R4: repeated column pairs across the range limit
        for (int h = 1; h <= 64; h++) begin
            int c;
            c = 'h81F + h;
            bus_write(0, c[7:0]);
            chk("R3 half pair", v_s, 0);
            bus_write(0, {4'h0, c[11:8]});
            chk("R3 valid", v_s, 1);
            chk("R3 col", col_s, c);
            chk("R3 cycle", cyc_s, 3 + 2 * h);
            chk("R4 col flag", ce_s, (c > 'h83F) ? 1 : 0);
        end
        bus_write(1, 8'hFF);
        chk("R11 code", code_s, 8'hFF);
        chk("R4 sticky status", data_o, 8'h90);
        bus_write(1, 8'h50);
        chk("R12 valid", v_s, 1);
        chk("R12 code", code_s, 8'h50);
        chk("R12 cleared", data_o, 8'h80);

        // R9: identifier read
        bus_write(1, 8'h90);
        chk("R9 valid", v_s, 1);
        chk("R9 code", code_s, 8'h90);
        code_sel_i = 1'b0; #1;
        chk("R9 maker", data_o, 8'h07);
        code_sel_i = 1'b1; #1;
        chk("R9 part", data_o, 8'h99);
        code_sel_i = 1'b0;

        // R10: every byte that opens no sequence
        bus_write(1, 8'hFF);
        for (int b = 0; b < 256; b++) begin
            if (b != 'h00 && b != 'h80 && b != 'h60 && b != 'h90 && b != 'h50 && b != 'hFF) begin
                bus_write(1, b[7:0]);
                chk("R10 no pulse", v_s, 0);
                chk("R10 cycle", cyc_s, 0);
                chk("R10 status", data_o, 8'hA0);
            end
        end
        bus_write(1, 8'h50);
        bus_write(0, 8'h12);
        chk("R10 stray address", data_o, 8'hA0);
        chk("R10 stray cycle", cycle_o, 0);
        bus_write(1, 8'h50);

        // R11: abort mid sequence
        bus_write(1, 8'h00);
        bus_write(0, 8'h34);
        chk("R11 partial cycle", cyc_s, 2);
        bus_write(1, 8'hFF);
        chk("R11 valid", v_s, 1);
        chk("R11 cycle", cyc_s, 0);
        chk("R11 status mode", data_o, 8'h80);
        bus_write(0, 8'h56);
        chk("R11 sequence dropped", data_o, 8'hA0);
        bus_write(1, 8'h50);

        // R5/R7: erase and busy window width
        bus_write(1, 8'h60);
        bus_write(0, 8'hAB);
        bus_write(0, 8'h2C);
        chk("R5 no pulse before confirm", v_s, 0);
        bus_write(1, 8'hD0);
        chk("R5 valid", v_s, 1);
        chk("R5 code", code_s, 8'h60);
        chk("R5 sector", sec_s, 14'h2CAB);
        chk("R5 cycle", cyc_s, 4);
        chk("R7 ready bit low", data_o, 8'h00);
        n = 2;
        forever begin
            @(posedge clk); #2;
            if (busy_o) n++; else break;
        end
        chk("R7 busy width", n, B);
        chk("R7 ready bit high", data_o, 8'h80);

        // R8: command during busy ignored
        bus_write(1, 8'h60);
        bus_write(0, 8'h01);
        bus_write(0, 8'h00);
        bus_write(1, 8'hD0);
        bus_write(1, 8'h90);
        chk("R8 ignored pulse", v_s, 0);
        chk("R8 ignored mode", data_o, 8'h00);
        wait_ready();
        chk("R8 mode kept", data_o, 8'h80);

        // R6: confirm without data
        bus_write(1, 8'h80);
        bus_write(0, 8'h10);
        bus_write(0, 8'h00);
        bus_write(1, 8'h40);
        chk("R6 early confirm no pulse", v_s, 0);
        chk("R6 early confirm err", data_o, 8'hA0);
        chk("R6 early confirm busy", busy_o, 0);
        bus_write(1, 8'h50);

        // R6: program with two column pairs and data
        bus_write(1, 8'h80);
        bus_write(0, 8'h77);
        bus_write(0, 8'h15);
        bus_write(0, 8'h00);
        bus_write(0, 8'h01);
        bus_write(0, 8'h3F);
        bus_write(0, 8'h08);
        chk("R6 no pulse on column", v_s, 0);
        ser_strobe(); ser_strobe(); ser_strobe();
        bus_write(1, 8'h40);
        chk("R6 valid", v_s, 1);
        chk("R6 code", code_s, 8'h80);
        chk("R6 sector", sec_s, 14'h1577);
        chk("R6 col", col_s, 12'h83F);
        chk("R4 limit col ok", ce_s, 0);
        chk("R6 cycle", cyc_s, 8);
        // R8: strobe captured in the last busy cycle
        repeat (B - 1) @(negedge clk);
        cmd_sel_i = 1'b1; bus_i = 8'h90; wr_en_i = 1'b1;
        @(posedge clk); #2;
        chk("R8 last busy cycle pulse", op_valid_o, 0);
        chk("R8 busy ends", busy_o, 0);
        @(negedge clk) wr_en_i = 1'b0;
        @(posedge clk); #2;
        chk("R8 last busy cycle mode", data_o, 8'h80);
        bus_write(1, 8'h90);
        chk("R8 accepted after busy", v_s, 1);
        chk("R8 ident after busy", data_o, 8'h07);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule